// File: doc/BRIEF.md
# SD Command Issuer with Response Capture

This block issues one SD bus command at a time and captures the card's reply. The host side presents a command index, a 32-bit argument, a response selector, a data-present flag and a command-type field, then pulses a start strobe. The block builds the 48-bit command frame, computes its CRC-7 and shifts the frame out on the command line. One card-clock cycle of the bit-serial model is one system clock cycle. It then waits for the card's response and checks it. For busy-signalling commands it also watches the data-0 line until the card lets go of it.

The captured response appears as four 32-bit words on one 128-bit port, with word i at bits 32i+31:32i. Long (136-bit) responses are presented in a realigned view. The stored form leaves out the CRC byte. In the view, each word moves up by one byte and takes the top byte of the word below it into its low byte.

Completion and error conditions set sticky status bits, and software clears each one by writing a 1 to it. While a command or a busy wait is in progress, the block refuses new commands.

Top module: `sdc_cmd_top`

## Requirements
- R1: `cmd_word` holds the accepted command, packed as follows:
  - bits 13:8 carry the index;
  - bits 7:6 carry the command type;
  - bit 5 carries the data-present flag;
  - bits 1:0 carry the length code: 00 no response, 01 136-bit, 10 48-bit, 11 48-bit with busy;
  - bits 15:14 and 4:2 read as zero.
- R2: On the cycle after acceptance, `cmd_oe` goes high for exactly 48 cycles. During those cycles `cmd_out` sends the frame most significant bit first: start bit 0, transmission bit 1, the 6-bit index, the 32-bit argument, a 7-bit CRC and end bit 1. When `cmd_oe` is low, `cmd_out` rests at 1.
- R3: The frame CRC is CRC-7 with generator x^7+x^3+1 and a zero initial value, taken over the first 40 frame bits. For index 0 with argument 0, the CRC is 7'h4A.
- R4: The response selector `rsp_sel` uses these codes: 0 none, 1 R1, 2 R1b, 3 R2, 4 R3, 5 R6, 6 R7. A 48-bit response (R1, R1b, R3, R6, R7) puts received frame bits 39:8 in word 0 and zeros in words 1 to 3.
- R5: For a 136-bit response (R2), the 120 content bits that come before the CRC byte form raw words 0 to 3. The port shows word i as raw word i shifted left by 8, with its low byte taken from the top byte of raw word i-1. Word 0's low byte is zero.
- R6: The response start bit (`cmd_in` low) is accepted on any of the 64 cycles after the command end bit. If the line stays high through all 64, status bit 2 (timeout) is set, the response words are left unchanged, and the command ends.
- R7: At the end of a 48-bit response the block makes three checks:
  - a CRC-7 mismatch over response bits 47:8 sets status bit 3;
  - an end bit of 0 sets status bit 4;
  - an index field (bits 45:40) different from the command index sets status bit 5.

  A 136-bit response is checked only for its end bit.
- R8: For R1b, after the response the block holds `dat_inhibit` high until `dat0_in` is sampled high. It then sets status bit 1 (transfer complete).
- R9: Status bit 0 (command complete) is set at the end bit of a command with no response, and at the last bit of a received response. All status bits reset to zero. Writing a 1 to a bit in `sts_clr` clears that bit and leaves the others unchanged.
- R10: A start strobe is ignored, with `cmd_word` and the command line untouched, in two cases: while `cmd_inhibit` or `dat_inhibit` is high, or when `rsp_sel` is 7.
- R11: A command with no response raises command complete on the same edge that ends its frame, without waiting for the card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one card-clock bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | Start strobe for a new command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_sel | input | 3 | Expected response type |
| data_flag | input | 1 | Data-present flag, packed into the command word |
| cmd_kind | input | 2 | Command-type field, packed into the command word |
| sts_clr | input | 6 | Write-one-to-clear strobes for the status bits |
| cmd_in | input | 1 | Command line from the card |
| dat0_in | input | 1 | Data-0 line from the card (low means busy) |
| cmd_out | output | 1 | Command line to the card |
| cmd_oe | output | 1 | Host drives the command line |
| cmd_word | output | 16 | Encoded command register |
| cmd_inhibit | output | 1 | Command in progress on the command line |
| dat_inhibit | output | 1 | Busy wait on data-0 in progress |
| sts | output | 6 | Status: 0 cmd done, 1 xfer done, 2 timeout, 3 CRC, 4 end bit, 5 index |
| rsp_words | output | 128 | Response words 0 to 3, realigned for 136-bit responses |

## Verification
The bench places the response start bit on the first and on the last cycle of the 64-cycle window, and also one cycle too late. A counter that is off by one would either time out on a valid reply or accept a late one. It sends responses with a flipped CRC bit, a zero end bit and a wrong index field, each of which must set only its own status bit, and a design that mixed up the checks would flag the wrong cause. A long response with a distinct byte in every position exposes any slip in the byte realignment between words. A busy wait held for many cycles, together with strobes sent during the send and busy phases, shows whether transfer complete is raised early or whether a refused command leaks into the command register.

// File: rtl/sdc_cmd_pkg.sv
// Package: shared types and helpers for the SD command issuer.
// Assumes frame lengths fixed by the SD command-line protocol.
package sdc_cmd_pkg;

    // Response selector codes seen on rsp_sel (7 is not a valid selector)
    typedef enum logic [2:0] {
        RSP_NONE = 3'd0,
        RSP_R1   = 3'd1,
        RSP_R1B  = 3'd2,
        RSP_R2   = 3'd3,
        RSP_R3   = 3'd4,
        RSP_R6   = 3'd5,
        RSP_R7   = 3'd6
    } rsp_sel_e;

    // Controller phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEND,
        PH_WAIT,
        PH_RECV,
        PH_BUSY
    } phase_e;

    localparam int IDX_W       = 6;
    localparam int ARG_W       = 32;
    localparam int CRC_W       = 7;
    localparam int FRAME_SHORT = 48;
    localparam int FRAME_LONG  = 136;
    localparam int CRC_SPAN    = 2 + IDX_W + ARG_W;   // bits covered by CRC
    localparam int VIEW_W      = 128;
    localparam int STS_W       = 6;

    // Status bit positions
    localparam int SB_CDONE = 0;
    localparam int SB_XDONE = 1;
    localparam int SB_TOUT  = 2;
    localparam int SB_CRC   = 3;
    localparam int SB_END   = 4;
    localparam int SB_IDX   = 5;

    // Length code placed in the low bits of the command word
    function automatic logic [1:0] len_code(input rsp_sel_e sel);
        case (sel)
            RSP_NONE: len_code = 2'b00;
            RSP_R2:   len_code = 2'b01;
            RSP_R1B:  len_code = 2'b11;
            default:  len_code = 2'b10;
        endcase
    endfunction

    // CRC-7, generator x^7 + x^3 + 1, zero seed, MSB first
    function automatic logic [CRC_W-1:0] crc7_calc(input logic [CRC_SPAN-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = CRC_SPAN - 1; i >= 0; i--) begin
            fb = d[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdc_cmd_tx.sv
// Module: command frame builder and serializer.
// Builds start/transmission bits, index, argument, CRC-7 and end bit,
// then shifts the frame out MSB first, one bit per shift pulse.
// Assumes load and shift are never asserted together.
module sdc_cmd_tx
    import sdc_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic             bit_out
);
    logic [FRAME_SHORT-1:0] frame;
    logic [FRAME_SHORT-1:0] sr;

    // Assemble the outgoing frame from the host fields
    always_comb begin
        frame = {2'b01, idx, arg, crc7_calc({2'b01, idx, arg}), 1'b1};
    end

    // Load a new frame or advance it by one bit
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= frame;
        else if (shift) sr <= {sr[FRAME_SHORT-2:0], 1'b0};
    end

    assign bit_out = sr[FRAME_SHORT-1];

endmodule

// File: rtl/sdc_rsp_rx.sv
// Module: response deserializer and checker.
// Shifts card bits in LSB first-arrived-at-top; the checks and the
// response view are computed on the frame including the bit arriving
// this cycle, so the controller can latch them on the final bit.
// Assumes the first 8 bits of a long frame (start, transmission,
// reserved) may fall off the top of the shift register.
module sdc_rsp_rx
    import sdc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              bit_in,
    input  logic              long_frm,
    input  logic [IDX_W-1:0]  exp_idx,
    output logic              crc_bad,
    output logic              end_bad,
    output logic              idx_bad,
    output logic [VIEW_W-1:0] view
);
    localparam int NWORD = VIEW_W / 32;

    logic [VIEW_W-2:0] sr;
    logic [VIEW_W-1:0] frm;
    logic [31:0]       raw  [NWORD];
    logic [VIEW_W-1:0] long_view;

    assign frm = {sr, bit_in};

    // Collect card bits while the controller is receiving
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (shift) sr <= frm[VIEW_W-2:0];
    end

    // Frame checks; long frames check only their end bit
    always_comb begin
        end_bad = !frm[0];
        crc_bad = !long_frm && (crc7_calc(frm[FRAME_SHORT-1:8]) != frm[7:1]);
        idx_bad = !long_frm && (frm[45:40] != exp_idx);
    end

    // Raw words hold the 120 content bits below the CRC byte,
    // realigned words move each one up a byte
    generate
        for (genvar w = 0; w < NWORD; w++) begin : g_word
            if (w < NWORD - 1) begin : g_full
                assign raw[w] = frm[8 + 32*w +: 32];
            end else begin : g_top
                assign raw[w] = {8'h00, frm[8 + 32*w +: 24]};
            end
            if (w == 0) begin : g_low
                assign long_view[31:0] = {raw[0][23:0], 8'h00};
            end else begin : g_up
                assign long_view[32*w +: 32] = {raw[w][23:0], raw[w-1][31:24]};
            end
        end
    endgenerate

    // Select the view for the frame length in use
    always_comb begin
        if (long_frm) view = long_view;
        else          view = {{(VIEW_W-32){1'b0}}, frm[39:8]};
    end

endmodule

// File: rtl/sdc_cmd_top.sv
// Module: SD command issuer top level.
// Accepts one command when idle, serializes it, waits up to TIMEOUT_CYC
// cycles for a response start bit, captures and checks the response,
// waits on data-0 for busy responses, and keeps sticky W1C status.
// Assumes one system clock cycle per card-clock bit.
module sdc_cmd_top
    import sdc_cmd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [5:0]        cmd_index,
    input  logic [31:0]       cmd_arg,
    input  logic [2:0]        rsp_sel,
    input  logic              data_flag,
    input  logic [1:0]        cmd_kind,
    input  logic [5:0]        sts_clr,
    input  logic              cmd_in,
    input  logic              dat0_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic [15:0]       cmd_word,
    output logic              cmd_inhibit,
    output logic              dat_inhibit,
    output logic [5:0]        sts,
    output logic [127:0]      rsp_words
);
    localparam int CNT_MAX = (TIMEOUT_CYC > FRAME_LONG) ? TIMEOUT_CYC : FRAME_LONG;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    phase_e             phase;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   last_cnt;
    logic [IDX_W-1:0]   idx_q;
    rsp_sel_e           sel_q;
    logic [15:0]        word_q;
    logic [STS_W-1:0]   sts_q;
    logic [STS_W-1:0]   sts_set;
    logic [VIEW_W-1:0]  rsp_q;
    logic               accept;
    logic               long_q;
    logic               tx_bit;
    logic               tx_end;
    logic               rx_shift;
    logic               rx_done;
    logic               tout_hit;
    logic               crc_bad;
    logic               end_bad;
    logic               idx_bad;
    logic [VIEW_W-1:0]  view;

    assign accept   = (phase == PH_IDLE) && cmd_go && (rsp_sel != 3'd7);
    assign long_q   = (sel_q == RSP_R2);
    assign last_cnt = long_q ? CNT_W'(FRAME_LONG - 1) : CNT_W'(FRAME_SHORT - 1);
    assign tx_end   = (phase == PH_SEND) && (cnt == CNT_W'(FRAME_SHORT - 1));
    assign rx_shift = ((phase == PH_WAIT) && !cmd_in) || (phase == PH_RECV);
    assign rx_done  = (phase == PH_RECV) && (cnt == last_cnt);
    assign tout_hit = (phase == PH_WAIT) && cmd_in && (cnt == CNT_W'(TIMEOUT_CYC - 1));

    sdc_cmd_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .shift   (phase == PH_SEND),
        .idx     (cmd_index),
        .arg     (cmd_arg),
        .bit_out (tx_bit)
    );

    sdc_rsp_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (rx_shift),
        .bit_in   (cmd_in),
        .long_frm (long_q),
        .exp_idx  (idx_q),
        .crc_bad  (crc_bad),
        .end_bad  (end_bad),
        .idx_bad  (idx_bad),
        .view     (view)
    );

    // Phase sequencing and the shared bit/timeout counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            idx_q  <= '0;
            sel_q  <= RSP_NONE;
            word_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    phase  <= PH_SEND;
                    cnt    <= '0;
                    idx_q  <= cmd_index;
                    sel_q  <= rsp_sel_e'(rsp_sel);
                    word_q <= {2'b00, cmd_index, cmd_kind, data_flag, 3'b000,
                               len_code(rsp_sel_e'(rsp_sel))};
                end
                PH_SEND: begin
                    if (tx_end) begin
                        cnt   <= '0;
                        phase <= (sel_q == RSP_NONE) ? PH_IDLE : PH_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (!cmd_in) begin
                        phase <= PH_RECV;
                        cnt   <= CNT_W'(1);
                    end else if (tout_hit) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RECV: begin
                    if (rx_done) phase <= (sel_q == RSP_R1B) ? PH_BUSY : PH_IDLE;
                    else         cnt   <= cnt + 1'b1;
                end
                PH_BUSY: if (dat0_in) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Capture the response view on the final response bit
    always_ff @(posedge clk) begin
        if (!rst_n)       rsp_q <= '0;
        else if (rx_done) rsp_q <= view;
    end

    // Status set conditions for this cycle
    always_comb begin
        sts_set           = '0;
        sts_set[SB_CDONE] = (tx_end && (sel_q == RSP_NONE)) || rx_done;
        sts_set[SB_XDONE] = (phase == PH_BUSY) && dat0_in;
        sts_set[SB_TOUT]  = tout_hit;
        sts_set[SB_CRC]   = rx_done && crc_bad;
        sts_set[SB_END]   = rx_done && end_bad;
        sts_set[SB_IDX]   = rx_done && idx_bad;
    end

    // Sticky status with write-one-to-clear; a new set wins
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~sts_clr) | sts_set;
    end

    assign cmd_oe      = (phase == PH_SEND);
    assign cmd_out     = cmd_oe ? tx_bit : 1'b1;
    assign cmd_word    = word_q;
    assign cmd_inhibit = (phase == PH_SEND) || (phase == PH_WAIT) || (phase == PH_RECV);
    assign dat_inhibit = (phase == PH_BUSY);
    assign sts         = sts_q;
    assign rsp_words   = rsp_q;

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);                                          // R2
    AST_END_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(cmd_out));                                    // R2
    AST_TIMEOUT_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[SB_TOUT]) |-> $past(cmd_in));                               // R6
    AST_XFER_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[SB_XDONE]) |-> ($past(dat0_in) && $past(dat_inhibit)));     // R8
    AST_REFUSED_WHILE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && (cmd_inhibit || dat_inhibit)) |=> $stable(cmd_word));      // R10
    AST_INHIBITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_inhibit, dat_inhibit, cmd_go && accept}));              // R10

endmodule

// File: tb/tb_sdc_cmd_top.sv
module tb_sdc_cmd_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cmd_go;
    logic [5:0]   cmd_index;
    logic [31:0]  cmd_arg;
    logic [2:0]   rsp_sel;
    logic         data_flag;
    logic [1:0]   cmd_kind;
    logic [5:0]   sts_clr;
    logic         cmd_in;
    logic         dat0_in;
    logic         cmd_out;
    logic         cmd_oe;
    logic [15:0]  cmd_word;
    logic         cmd_inhibit;
    logic         dat_inhibit;
    logic [5:0]   sts;
    logic [127:0] rsp_words;

    int n_checks = 0;
    int n_fail   = 0;
    logic [47:0] last_frame;

    typedef struct {
        string        tag;
        logic [5:0]   sts;
        logic [127:0] rsp;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    sdc_cmd_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .rsp_sel(rsp_sel), .data_flag(data_flag),
        .cmd_kind(cmd_kind), .sts_clr(sts_clr), .cmd_in(cmd_in),
        .dat0_in(dat0_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .cmd_word(cmd_word), .cmd_inhibit(cmd_inhibit),
        .dat_inhibit(dat_inhibit), .sts(sts), .rsp_words(rsp_words)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // CRC-7 by long division of message * x^7 by 0x89
    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [46:0] r;
        r = {m, 7'b0};
        for (int i = 46; i >= 7; i--)
            if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
        return r[6:0];
    endfunction

    function automatic logic [1:0] ref_code(input logic [2:0] sel);
        case (sel)
            3'd0:    return 2'b00;
            3'd3:    return 2'b01;
            3'd2:    return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] pl);
        return {88'h0, 1'b0, 1'b0, idx, pl, ref_crc({2'b00, idx, pl}), 1'b1};
    endfunction

    // Monitor: pops an expectation each time a command leaves the line
    logic prev_inh = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (prev_inh && !cmd_inhibit) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9 unexpected completion", {122'h0, sts}, 128'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(sts == e.sts, {e.tag, " status"}, {122'h0, sts}, {122'h0, e.sts});
                    check(rsp_words == e.rsp, {e.tag, " response"}, rsp_words, e.rsp);
                end
            end
            prev_inh = cmd_inhibit;
        end
    end

    task automatic clear_all();
        @(negedge clk); sts_clr = 6'h3f;
        @(negedge clk); sts_clr = 6'h00;
    endtask

    // Driver: issues a command, checks the frame, plays the card's reply
    task automatic run_cmd(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                           input logic [2:0] sel, input logic df, input logic [1:0] kind,
                           input logic [135:0] rfrm, input int rlen, input int gap,
                           input logic [5:0] exp_sts, input logic [127:0] exp_rsp,
                           input bit poke);
        logic [47:0] got;
        logic [47:0] want;
        logic [15:0] want_word;
        bit          oe_ok;
        exp_t        e;
        e.tag = tag; e.sts = exp_sts; e.rsp = exp_rsp;
        sb_q.push_back(e);
        want      = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
        want_word = {2'b00, idx, kind, df, 3'b000, ref_code(sel)};
        oe_ok     = 1'b1;
        @(negedge clk);
        cmd_index = idx; cmd_arg = arg; rsp_sel = sel; data_flag = df; cmd_kind = kind;
        cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        for (int b = 47; b >= 0; b--) begin
            got[b] = cmd_out;
            oe_ok  = oe_ok && cmd_oe;
            if (poke && b == 30) begin cmd_go = 1'b1; cmd_index = idx ^ 6'h15; end
            if (poke && b == 29) begin cmd_go = 1'b0; cmd_index = idx; end
            @(negedge clk);
        end
        last_frame = got;
        check(got == want, {tag, " R2 frame"}, {80'h0, got}, {80'h0, want});
        check(oe_ok && !cmd_oe, {tag, " R2 drive window"}, {127'h0, cmd_oe}, 128'h0);
        check(cmd_word == want_word, {tag, " R1 command word"}, {112'h0, cmd_word}, {112'h0, want_word});
        if (rlen > 0) begin
            repeat (gap) @(negedge clk);
            for (int b = rlen - 1; b >= 0; b--) begin
                cmd_in = rfrm[b];
                @(negedge clk);
            end
            cmd_in = 1'b1;
        end else if (sel != 3'd0) begin
            repeat (gap) @(negedge clk);
        end
        @(negedge clk);
        check(sb_q.size() == 0, {tag, " R9 completion seen"}, sb_q.size(), 128'h0);
    endtask

    initial begin
        logic [135:0] fr;
        logic [127:0] cur_rsp;
        logic [15:0]  w_hold;
        bit           quiet;
        rst_n = 1'b0; cmd_go = 1'b0; cmd_index = '0; cmd_arg = '0; rsp_sel = '0;
        data_flag = 1'b0; cmd_kind = '0; sts_clr = '0; cmd_in = 1'b1; dat0_in = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sts == 6'h00, "R9 reset status", {122'h0, sts}, 128'h0);
        check(!cmd_inhibit && !dat_inhibit && !cmd_oe && cmd_out,
              "R2 reset line idle", {124'h0, cmd_inhibit, dat_inhibit, cmd_oe, cmd_out}, 128'h1);
        check(rsp_words == '0, "R4 reset response", rsp_words, 128'h0);

        // R11: no-response command completes at its end bit
        run_cmd("R11 no response", 6'd0, 32'h0, 3'd0, 1'b0, 2'b00, '0, 0, 0, 6'h01, 128'h0, 1'b0);
        check(last_frame[7:1] == 7'h4A, "R3 known CRC", {121'h0, last_frame[7:1]}, 128'h4A);
        clear_all();

        // R4: R1 with gap 3
        cur_rsp = {96'h0, 32'hCAFEF00D};
        run_cmd("R4 R1 capture", 6'd17, 32'h12345678, 3'd1, 1'b0, 2'b00,
                short_rsp(6'd17, 32'hCAFEF00D), 48, 3, 6'h01, cur_rsp, 1'b0);
        clear_all();

        // R6 first window cycle; R10 strobe during send is refused
        cur_rsp = {96'h0, 32'hAAAA5555};
        run_cmd("R6 R10 R6-type gap0 poke", 6'd3, 32'h0000FFFF, 3'd5, 1'b0, 2'b10,
                short_rsp(6'd3, 32'hAAAA5555), 48, 0, 6'h01, cur_rsp, 1'b1);
        clear_all();

        // R6 last window cycle; R1 data flag and type in word
        cur_rsp = {96'h0, 32'h000001AA};
        run_cmd("R6 R7-type gap63", 6'd8, 32'h000001AA, 3'd6, 1'b1, 2'b10,
                short_rsp(6'd8, 32'h000001AA), 48, 63, 6'h01, cur_rsp, 1'b0);
        clear_all();

        // R6 start bit one cycle late: timeout, response unchanged
        run_cmd("R6 late start timeout", 6'd41, 32'h40FF8000, 3'd4, 1'b0, 2'b00,
                short_rsp(6'd63, 32'h00FF8000), 48, 64, 6'h04, cur_rsp, 1'b0);
        repeat (3) @(negedge clk);
        check(sts == 6'h04 && rsp_words == cur_rsp, "R6 late reply ignored",
              {122'h0, sts}, 128'h04);
        clear_all();

        // R7: CRC error
        fr = short_rsp(6'd13, 32'h0BADBEEF); fr[1] = ~fr[1];
        cur_rsp = {96'h0, 32'h0BADBEEF};
        run_cmd("R7 crc error", 6'd13, 32'h1, 3'd1, 1'b0, 2'b00, fr, 48, 2, 6'h09, cur_rsp, 1'b0);
        // R9: partial write-one-to-clear
        @(negedge clk); sts_clr = 6'h08;
        @(negedge clk); sts_clr = 6'h00;
        check(sts == 6'h01, "R9 clear crc bit only", {122'h0, sts}, 128'h01);
        @(negedge clk); sts_clr = 6'h01;
        @(negedge clk); sts_clr = 6'h00;
        check(sts == 6'h00, "R9 clear done bit", {122'h0, sts}, 128'h00);

        // R7: end bit error
        fr = short_rsp(6'd16, 32'h00000200); fr[0] = 1'b0;
        cur_rsp = {96'h0, 32'h00000200};
        run_cmd("R7 end bit error", 6'd16, 32'h200, 3'd1, 1'b0, 2'b00, fr, 48, 1, 6'h11, cur_rsp, 1'b0);
        clear_all();

        // R7: index mismatch with valid CRC
        cur_rsp = {96'h0, 32'h00000900};
        run_cmd("R7 index error", 6'd9, 32'h0, 3'd1, 1'b0, 2'b00,
                short_rsp(6'd10, 32'h00000900), 48, 4, 6'h21, cur_rsp, 1'b0);
        clear_all();

        // R5: long response realignment
        fr = {2'b00, 6'h3f, 32'h11223344, 32'h55667788, 32'h99AABBCC, 31'h5DEEFF01, 1'b1};
        cur_rsp = {fr[127:8], 8'h00};
        run_cmd("R5 long response", 6'd2, 32'h0, 3'd3, 1'b0, 2'b00, fr, 136, 5, 6'h01, cur_rsp, 1'b0);
        check(rsp_words[7:0] == 8'h00 && rsp_words[39:32] == fr[39:32],
              "R5 word1 low byte from word0 top", rsp_words[63:32], {96'h0, fr[63:40], fr[39:32]});
        clear_all();

        // R8: busy wait on data-0
        dat0_in = 1'b0;
        cur_rsp = {96'h0, 32'h00000900};
        run_cmd("R8 busy response", 6'd7, 32'h00010000, 3'd2, 1'b0, 2'b11,
                short_rsp(6'd7, 32'h00000900), 48, 2, 6'h01, cur_rsp, 1'b0);
        check(dat_inhibit && !cmd_inhibit, "R8 data inhibit held",
              {126'h0, dat_inhibit, cmd_inhibit}, 128'h2);
        // R10: strobe during busy is refused
        w_hold = cmd_word;
        cmd_index = 6'd9; rsp_sel = 3'd1; cmd_go = 1'b1;
        @(negedge clk); cmd_go = 1'b0;
        quiet = 1'b1;
        repeat (20) begin
            @(negedge clk);
            quiet = quiet && !cmd_oe;
        end
        check(quiet && cmd_word == w_hold, "R10 refused during busy",
              {112'h0, cmd_word}, {112'h0, w_hold});
        check(sts[1] == 1'b0, "R8 no transfer complete while busy", {127'h0, sts[1]}, 128'h0);
        dat0_in = 1'b1;
        @(negedge clk);
        check(sts[1] == 1'b1 && !dat_inhibit, "R8 transfer complete on release",
              {126'h0, sts[1], dat_inhibit}, 128'h2);
        clear_all();

        // R10: invalid selector ignored
        w_hold = cmd_word;
        @(negedge clk);
        cmd_index = 6'd33; rsp_sel = 3'd7; cmd_go = 1'b1;
        @(negedge clk); cmd_go = 1'b0;
        quiet = 1'b1;
        repeat (4) begin
            quiet = quiet && !cmd_oe && !cmd_inhibit;
            @(negedge clk);
        end
        check(quiet && cmd_word == w_hold, "R10 invalid selector ignored",
              {112'h0, cmd_word}, {112'h0, w_hold});

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule